// File: doc/BRIEF.md
# Flit Lane Serializer with Width Degradation

This block takes whole 80-bit link units from an upstream stage and spreads them over a parallel bundle of 20 transmit lanes. The bundle is built from four quadrants of five lanes each. When a quadrant fails, the link keeps running at reduced width: half width on 10 lanes, or quarter width on 5 lanes. The same unit is then cut into 4, 8 or 16 beats. Each unit holds a payload in its low 64 bits, a header byte above that, and an error-check byte at the top. The check byte arrives already filled in.

Beats run at twice the clock rate, so each clock cycle carries two beats. They appear on two lane words, `lane_even` and `lane_odd`, and a downstream double-data-rate stage drives them on the two clock edges. Upstream handshake: a unit is taken on a clock edge where `unit_valid` and `unit_ready` are both high. While a unit is going out, `unit_ready` is low and a waiting producer must hold its unit stable. `unit_ready` rises again during the final cycle of the current unit, so a unit that is waiting follows with no idle beat in between. The lane side has no back-pressure.

`width_sel` is a plain control input. It is read only on the cycle a unit is accepted, so a change made while a unit is going out applies from the next unit onward.

Top module: `flit_lane_tx`

## Requirements
- R1: While reset is held and just after it is released: `lane_valid`=0, `lane_first`=0, both lane words are zero, and `unit_ready`=1.
- R2: Unit layout is check byte in [79:72], header in [71:64] and payload in [63:0]. Beats go out least-significant slice first: beat b of width-w operation carries unit bits [b*w +: w] on lanes [w-1:0].
- R3: A unit accepted at edge t shows beats 0 and 1 in the cycle after t. In the k-th cycle of the unit, beat 2k is on `lane_even` and beat 2k+1 is on `lane_odd`.
- R4: `width_sel`=0 (full) uses all 20 lanes. The unit takes 4 beats, which is 2 cycles.
- R5: `width_sel`=1 (half) uses lanes [9:0]. The unit takes 8 beats (4 cycles), and lanes [19:10] are 0.
- R6: `width_sel`=2 (quarter) uses lanes [4:0]. The unit takes 16 beats (8 cycles), and lanes [19:5] are 0. The code 3 behaves the same as 2.
- R7: `lane_first` is 1 exactly in the cycle carrying beat 0 of a unit. In every other cycle it is 0.
- R8: `unit_ready` is 0 from the cycle after acceptance until the last cycle of the unit. It is 1 in that last cycle and whenever idle. A unit offered while `unit_ready` is 0 is not taken.
- R9: A unit accepted in the last cycle of the previous unit starts in the very next cycle, with no idle cycle in between.
- R10: `width_sel` is sampled only at acceptance. A change made while a unit is going out has no effect on that unit.
- R11: With no unit in flight, `lane_valid`=0 and both lane words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| width_sel | input | 2 | Lane width: 0 full, 1 half, 2 or 3 quarter |
| unit_valid | input | 1 | Upstream unit offered |
| unit_ready | output | 1 | Block can take a unit this cycle |
| unit_data | input | 80 | Unit: check[79:72], header[71:64], payload[63:0] |
| lane_valid | output | 1 | Lane words carry beats this cycle |
| lane_first | output | 1 | This cycle carries beat 0 of a unit |
| lane_even | output | 20 | First beat of the cycle |
| lane_odd | output | 20 | Second beat of the cycle |

## Verification
The assertions assume that `unit_valid` stays low during reset. They also assume that a unit offered while `unit_ready` is low is held until it is taken, since only a held unit gives a meaningful back-to-back check. The stimulus changes inputs only on the falling clock edge. It keeps `unit_valid` and `unit_data` fixed while it waits, and it changes `width_sel` freely in the middle of a unit to exercise R10. All four `width_sel` codes are driven, including the code 3 that maps to quarter width.

// File: rtl/flt_pkg.sv
package flt_pkg;
  localparam int UNIT_BITS  = 80;
  localparam int QUAD_LANES = 5;
  localparam int NUM_QUADS  = 4;
  localparam int LANES      = QUAD_LANES * NUM_QUADS;

  typedef enum logic [1:0] {
    WD_FULL    = 2'd0,
    WD_HALF    = 2'd1,
    WD_QUARTER = 2'd2,
    WD_QALT    = 2'd3
  } width_t;

  // fold the spare code onto quarter width
  function automatic width_t width_norm(input logic [1:0] code);
    case (code)
      2'd0:    return WD_FULL;
      2'd1:    return WD_HALF;
      default: return WD_QUARTER;
    endcase
  endfunction

  // active lanes per width
  function automatic int active_lanes(input width_t w);
    case (w)
      WD_FULL: return LANES;
      WD_HALF: return LANES / 2;
      default: return QUAD_LANES;
    endcase
  endfunction
endpackage

// File: rtl/flt_unit_ctrl.sv
module flt_unit_ctrl
  import flt_pkg::*;
#(
  parameter int UBITS = UNIT_BITS,
  parameter int QL    = QUAD_LANES,
  localparam int MAX_CYC = UBITS / (2 * QL),
  localparam int CW      = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [1:0] width_code,
  output logic       in_ready,
  output logic       accept,
  output logic       busy,
  output logic       last_cyc,
  output logic       first_cyc,
  output width_t     width_q
);
  localparam int FULL_CYC = UBITS / (2 * QL * NUM_QUADS);
  localparam int HALF_CYC = UBITS / (QL * NUM_QUADS);

  logic [CW-1:0] cyc_cnt;
  logic [CW-1:0] cyc_last;

  always_comb begin
    case (width_q)
      WD_FULL: cyc_last = CW'(FULL_CYC - 1);
      WD_HALF: cyc_last = CW'(HALF_CYC - 1);
      default: cyc_last = CW'(MAX_CYC - 1);
    endcase
  end

  assign last_cyc  = busy && (cyc_cnt == cyc_last);
  assign first_cyc = busy && (cyc_cnt == '0);
  assign in_ready  = !busy || last_cyc;
  assign accept    = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cyc_cnt <= '0;
      width_q <= WD_FULL;
    end else if (accept) begin
      busy    <= 1'b1;
      cyc_cnt <= '0;
      width_q <= width_norm(width_code);
    end else if (busy) begin
      if (last_cyc) begin
        busy    <= 1'b0;
        cyc_cnt <= '0;
      end else begin
        cyc_cnt <= cyc_cnt + 1'b1;
      end
    end
  end

  // R8: a freshly accepted unit always spans more than one cycle
  p_ready_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  // R10: width held for the whole unit
  p_width_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !first_cyc) |-> $stable(width_q));
endmodule

// File: rtl/flt_beat_slicer.sv
module flt_beat_slicer
  import flt_pkg::*;
#(
  parameter int UBITS = UNIT_BITS,
  parameter int QL    = QUAD_LANES,
  parameter int NQ    = NUM_QUADS,
  localparam int NL   = QL * NQ
) (
  input  width_t           width,
  input  logic             busy,
  input  logic [UBITS-1:0] hold,
  output logic [NL-1:0]    even_w,
  output logic [NL-1:0]    odd_w
);
  // per quadrant: which widths drive it, and from where
  for (genvar q = 0; q < NQ; q++) begin : g_quad
    localparam int LO = q * QL;
    logic [QL-1:0] ev_full, od_full, ev_half, od_half, ev_qtr, od_qtr;

    assign ev_full = hold[LO +: QL];
    assign od_full = hold[NL + LO +: QL];

    if (q < NQ / 2) begin : g_half
      assign ev_half = hold[LO +: QL];
      assign od_half = hold[NL / 2 + LO +: QL];
    end else begin : g_half_off
      assign ev_half = '0;
      assign od_half = '0;
    end

    if (q == 0) begin : g_qtr
      assign ev_qtr = hold[QL-1:0];
      assign od_qtr = hold[2*QL-1:QL];
    end else begin : g_qtr_off
      assign ev_qtr = '0;
      assign od_qtr = '0;
    end

    always_comb begin
      if (!busy) begin
        even_w[LO +: QL] = '0;
        odd_w[LO +: QL]  = '0;
      end else begin
        case (width)
          WD_FULL: begin
            even_w[LO +: QL] = ev_full;
            odd_w[LO +: QL]  = od_full;
          end
          WD_HALF: begin
            even_w[LO +: QL] = ev_half;
            odd_w[LO +: QL]  = od_half;
          end
          default: begin
            even_w[LO +: QL] = ev_qtr;
            odd_w[LO +: QL]  = od_qtr;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/flit_lane_tx.sv
module flit_lane_tx
  import flt_pkg::*;
#(
  parameter int UBITS = UNIT_BITS,
  parameter int QL    = QUAD_LANES,
  parameter int NQ    = NUM_QUADS,
  localparam int NL   = QL * NQ
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       width_sel,
  input  logic             unit_valid,
  output logic             unit_ready,
  input  logic [UBITS-1:0] unit_data,
  output logic             lane_valid,
  output logic             lane_first,
  output logic [NL-1:0]    lane_even,
  output logic [NL-1:0]    lane_odd
);
  logic             accept, busy, last_cyc, first_cyc;
  width_t           width_q;
  logic [UBITS-1:0] hold;

  flt_unit_ctrl #(.UBITS(UBITS), .QL(QL)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (unit_valid),
    .width_code(width_sel),
    .in_ready  (unit_ready),
    .accept    (accept),
    .busy      (busy),
    .last_cyc  (last_cyc),
    .first_cyc (first_cyc),
    .width_q   (width_q)
  );

  // shift register: two slices leave per cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0;
    end else if (accept) begin
      hold <= unit_data;
    end else if (busy) begin
      case (width_q)
        WD_FULL: hold <= hold >> (2 * NL);
        WD_HALF: hold <= hold >> NL;
        default: hold <= hold >> (2 * QL);
      endcase
    end
  end

  flt_beat_slicer #(.UBITS(UBITS), .QL(QL), .NQ(NQ)) u_slice (
    .width (width_q),
    .busy  (busy),
    .hold  (hold),
    .even_w(lane_even),
    .odd_w (lane_odd)
  );

  assign lane_valid = busy;
  assign lane_first = first_cyc;

  // R7, R9: accepted unit starts in the next cycle with beat 0
  p_first_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_valid && unit_ready) |=> (lane_valid && lane_first));

  // R11: idle lanes quiet
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_valid |-> (lane_even == '0 && lane_odd == '0 && !lane_first));

  // R6: quarter width leaves upper quadrants at zero
  p_quarter_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_valid && width_q == WD_QUARTER) |->
      (lane_even[NL-1:QL] == '0 && lane_odd[NL-1:QL] == '0));

  // R5: half width leaves upper two quadrants at zero
  p_half_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_valid && width_q == WD_HALF) |->
      (lane_even[NL-1:NL/2] == '0 && lane_odd[NL-1:NL/2] == '0));
endmodule

// File: tb/flit_lane_tx_test.sv
`timescale 1ns/1ps
module flit_lane_tx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  width_sel = 2'd0;
  logic        unit_valid = 1'b0;
  logic        unit_ready;
  logic [79:0] unit_data = '0;
  logic        lane_valid, lane_first;
  logic [19:0] lane_even, lane_odd;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  flit_lane_tx uut (
    .clk(clk), .rst_n(rst_n), .width_sel(width_sel),
    .unit_valid(unit_valid), .unit_ready(unit_ready), .unit_data(unit_data),
    .lane_valid(lane_valid), .lane_first(lane_first),
    .lane_even(lane_even), .lane_odd(lane_odd)
  );

  // {width code, unit}
  localparam logic [81:0] VEC [6] = '{
    {2'd0, 80'hA5_3C_0123_4567_89AB_CDEF},
    {2'd1, 80'h5A_C3_FEDC_BA98_7654_3210},
    {2'd2, 80'h81_7E_DEAD_BEEF_CAFE_F00D},
    {2'd3, 80'h0F_F0_1357_9BDF_2468_ACE0},
    {2'd0, 80'hFFFF_FFFF_FFFF_FFFF_FFFF},
    {2'd1, 80'hAAAA_5555_AAAA_5555_AAAA}
  };

  function automatic int width_of(input logic [1:0] c);
    return (c == 2'd0) ? 20 : (c == 2'd1) ? 10 : 5;
  endfunction

  function automatic logic [79:0] beat_of(input logic [79:0] f, input int w, input int b);
    logic [79:0] mask;
    mask = (80'd1 << w) - 80'd1;
    return (f >> (b * w)) & mask;
  endfunction

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // called at the negedge of the first cycle of the unit
  task automatic expect_unit(input logic [79:0] f, input logic [1:0] code, input string req);
    int w, n;
    w = width_of(code);
    n = 80 / (2 * w);
    for (int k = 0; k < n; k++) begin
      chk({req, " R3 valid"}, 80'(lane_valid), 80'd1);
      chk({req, " R7 first"}, 80'(lane_first), 80'(k == 0));
      chk({req, " R2 even"}, 80'(lane_even), beat_of(f, w, 2 * k));
      chk({req, " R2 odd"}, 80'(lane_odd), beat_of(f, w, 2 * k + 1));
      chk({req, " R8 ready"}, 80'(unit_ready), 80'(k == n - 1));
      if (k < n - 1) @(negedge clk);
    end
  endtask

  task automatic check_idle(input string req);
    chk({req, " R11 valid"}, 80'(lane_valid), 80'd0);
    chk({req, " R11 lanes"}, {40'd0, lane_even, lane_odd}, 80'd0);
    chk({req, " R11 ready"}, 80'(unit_ready), 80'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", 80'(unit_ready), 80'd1);
    chk("R1 valid in reset", 80'(lane_valid), 80'd0);
    chk("R1 first in reset", 80'(lane_first), 80'd0);
    chk("R1 lanes in reset", {40'd0, lane_even, lane_odd}, 80'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after reset");

    // table walk: R4 full, R5 half, R6 quarter (codes 2 and 3)
    for (int i = 0; i < 6; i++) begin
      unit_valid = 1'b1;
      width_sel  = VEC[i][81:80];
      unit_data  = VEC[i][79:0];
      @(negedge clk);
      unit_valid = 1'b0;
      unit_data  = '0;
      expect_unit(VEC[i][79:0], VEC[i][81:80],
                  (VEC[i][81:80] == 2'd0) ? "R4 table" :
                  (VEC[i][81:80] == 2'd1) ? "R5 table" : "R6 table");
      @(negedge clk);
      check_idle("R11 between");
    end

    // R10: width change mid-unit ignored
    unit_valid = 1'b1; width_sel = 2'd0; unit_data = 80'h12_34_5678_9ABC_DEF0_1357;
    @(negedge clk);
    unit_valid = 1'b0; width_sel = 2'd2;
    expect_unit(80'h12_34_5678_9ABC_DEF0_1357, 2'd0, "R10 mid change");
    @(negedge clk);
    check_idle("R10 after");

    // R8, R9: second unit held while first shifts, then follows without gap
    unit_valid = 1'b1; width_sel = 2'd1; unit_data = 80'hC0_DE_0011_2233_4455_6677;
    @(negedge clk);
    width_sel = 2'd2; unit_data = 80'h9A_BC_8899_AABB_CCDD_EEFF;
    expect_unit(80'hC0_DE_0011_2233_4455_6677, 2'd1, "R8 hold");
    @(negedge clk);
    unit_valid = 1'b0;
    expect_unit(80'h9A_BC_8899_AABB_CCDD_EEFF, 2'd2, "R9 back to back");
    @(negedge clk);
    check_idle("R9 after");

    // R9: full then full back to back, width switch at boundary
    unit_valid = 1'b1; width_sel = 2'd0; unit_data = 80'h11_22_3344_5566_7788_99AA;
    @(negedge clk);
    width_sel = 2'd3; unit_data = 80'hBB_CC_DDEE_FF00_1122_3344;
    expect_unit(80'h11_22_3344_5566_7788_99AA, 2'd0, "R9 first");
    @(negedge clk);
    unit_valid = 1'b0;
    expect_unit(80'hBB_CC_DDEE_FF00_1122_3344, 2'd3, "R6 code3 chained");
    @(negedge clk);
    check_idle("R11 end");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule